// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codeword Decoder

This block accepts one extended Hamming codeword and returns the data word carried inside it. It also reports how the word arrived: intact, repaired, or damaged beyond repair. Any single flipped bit is repaired. Any two flipped bits are detected and reported, and the data is left exactly as it was found. The data width is a parameter. The reference build carries 64 data bits in a 72-bit word: 7 position checks plus one overall parity bit.

Inside the block there are four steps. The first step pulls the data bits out of their codeword slots. The second step forms a syndrome from the whole word. The third step turns the syndrome into a correction mask with at most one bit set. The last step applies that mask to the extracted data. Two parameters can each add a register stage. One stage sits after extraction and syndrome generation, and the other sits on the outputs. Together they give a latency of zero, one or two cycles. The block sits on the read path of a protected store, one word per clock.

Top module: `secded_decoder`

## Requirements
- R1: Codeword index k (0-based), for k below TOTAL-1, holds Hamming position k+1. Data bit n comes from the n-th position, counted upward, that is not a power of two; for 64 data bits these are positions 3,5,6,7,9,…,71. Index TOTAL-1 (71) holds overall parity. A codeword with no error returns its data unchanged.
- R2: The syndrome low bit i (i = 0..P-1) is the XOR of every codeword bit at positions 1..TOTAL-1 whose position has bit i set. The syndrome top bit is the XOR of all TOTAL bits.
- R3: `flag_clean` is 1 exactly when the whole syndrome is zero.
- R4: A single flipped data bit is corrected, and `flag_fixed` is set. `flag_fixed` equals the syndrome top bit.
- R5: A single flipped check bit or overall-parity bit leaves the data unchanged and still sets `flag_fixed`.
- R6: When the low syndrome is nonzero and the top bit is 0, `flag_fatal` is set. The correction mask is then all zeros, so any two flipped bits give the raw extracted data uncorrected.
- R7: In every cycle outside reset, at most one of the three flags is 1, and the correction mask has at most one bit set.
- R8: The latency from `code_in` to the outputs is MID_STAGE + OUT_STAGE cycles; with both parameters 0 the path is combinational.
- R9: Reset is synchronous and active low. While `rst_n` is 0, every register stage clears to zero, so a registered output shows zero data and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | TOTAL (72) | Received codeword |
| data_out | output | DATA_W (64) | Data, corrected where possible |
| flag_clean | output | 1 | Syndrome was zero |
| flag_fixed | output | 1 | Odd overall parity: single error handled |
| flag_fatal | output | 1 | Double error detected; data not altered |

## Verification
Suppose the syndrome register or the position table held a wrong value. Then a single-bit error would show up at the ports as a wrong data bit: either a second bit flipped, or the damaged bit left as it was. With both stages present, this appears exactly two cycles after the word is presented. A fault in the gating from the fatal condition would show up only on double errors, as a data word that differs from the raw extraction. For that reason, both single errors (at every position) and double errors are compared bit for bit against an independent model.

// File: rtl/secded_pkg.sv
// Package: widths and position helpers shared by the decoder modules.
// Assumes a Hamming layout with check bits at power-of-two positions.
package secded_pkg;

    // Number of position check bits needed to protect dw data bits.
    function automatic int check_bits(input int dw);
        int p;
        p = 0;
        for (int i = 0; i < 32; i++) begin
            if ((1 << p) < dw + p + 1) p = p + 1;
        end
        return p;
    endfunction

    // True when pos is a power of two (check-bit slot).
    function automatic bit is_check_pos(input int pos);
        return (pos & (pos - 1)) == 0;
    endfunction

    // Hamming position (1-based) of data bit n.
    function automatic int data_pos(input int n, input int total);
        int cnt;
        int found;
        cnt   = 0;
        found = 0;
        for (int p = 1; p < total; p++) begin
            if (!is_check_pos(p)) begin
                if (cnt == n) found = p;
                cnt = cnt + 1;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/secded_extract.sv
// Module: pulls the raw (uncorrected) data bits out of a codeword,
// optionally through a register stage. Assumes code is TOTAL bits wide.
module secded_extract #(
    parameter int DATA_W = 64,
    parameter int TOTAL  = 72,
    parameter bit STAGE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOTAL-1:0]  code,
    output logic [DATA_W-1:0] raw
);
    import secded_pkg::*;

    logic [DATA_W-1:0] raw_c;

    // Wire each data bit from its non-power-of-two slot.
    for (genvar n = 0; n < DATA_W; n++) begin : g_pick
        localparam int POS = data_pos(n, TOTAL);
        assign raw_c[n] = code[POS-1];
    end

    if (STAGE) begin : g_reg
        logic [DATA_W-1:0] raw_q;
        // Middle pipeline register for the raw data.
        always_ff @(posedge clk) begin
            if (!rst_n) raw_q <= '0;
            else        raw_q <= raw_c;
        end
        assign raw = raw_q;
    end else begin : g_comb
        assign raw = raw_c;
    end
endmodule

// File: rtl/secded_syndrome.sv
// Module: forms the syndrome. The low P bits point at the failing position;
// the top bit is overall parity. Optional register stage.
module secded_syndrome #(
    parameter int TOTAL = 72,
    parameter int P     = 7,
    parameter bit STAGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] code,
    output logic [P:0]       syn
);
    logic [P:0] syn_c;

    // XOR the codeword bits selected by each position bit, plus full parity.
    always_comb begin
        syn_c = '0;
        for (int k = 0; k < TOTAL - 1; k++) begin
            for (int i = 0; i < P; i++) begin
                if ((((k + 1) >> i) & 1) == 1) syn_c[i] = syn_c[i] ^ code[k];
            end
        end
        syn_c[P] = ^code;
    end

    if (STAGE) begin : g_reg
        logic [P:0] syn_q;
        // Middle pipeline register for the syndrome.
        always_ff @(posedge clk) begin
            if (!rst_n) syn_q <= '0;
            else        syn_q <= syn_c;
        end
        assign syn = syn_q;
    end else begin : g_comb
        assign syn = syn_c;
    end
endmodule

// File: rtl/secded_correct.sv
// Module: turns a syndrome into a correction mask and the fatal indication.
// Purely combinational. The mask is empty on a double error or when the
// syndrome names a check-bit slot.
module secded_correct #(
    parameter int DATA_W = 64,
    parameter int TOTAL  = 72,
    parameter int P      = 7
) (
    input  logic [P:0]        syn,
    output logic [DATA_W-1:0] mask,
    output logic              fatal
);
    import secded_pkg::*;

    logic [P-1:0] ptr;

    assign ptr   = syn[P-1:0];
    assign fatal = (|ptr) & ~syn[P];

    // One comparator per data bit against its own position.
    for (genvar n = 0; n < DATA_W; n++) begin : g_mask
        localparam int POS = data_pos(n, TOTAL);
        assign mask[n] = ~fatal & (ptr == POS[P-1:0]);
    end

    // Guard the mask against multi-bit or ungated flips.
    always_comb begin
        if (!$isunknown(syn)) begin
            a_r7_mask_onehot0: assert ($onehot0(mask));
            a_r6_fatal_no_flip: assert (!fatal || mask == '0);
            a_r4_flip_needs_parity: assert (mask == '0 || syn[P]);
        end
    end
endmodule

// File: rtl/secded_decoder.sv
// Module: top of the decoder. Combines extraction, syndrome and correction,
// classifies the word and optionally registers the outputs.
// Assumes TOTAL = DATA_W + P + 1 with overall parity in the top bit.
module secded_decoder #(
    parameter int DATA_W    = 64,
    parameter bit MID_STAGE = 1'b1,
    parameter bit OUT_STAGE = 1'b1,
    localparam int P        = secded_pkg::check_bits(DATA_W),
    localparam int TOTAL    = DATA_W + P + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOTAL-1:0]  code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              flag_clean,
    output logic              flag_fixed,
    output logic              flag_fatal
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] mask;
    logic [P:0]        syn;
    logic              fatal;
    logic [DATA_W-1:0] data_c;
    logic              clean_c;

    secded_extract #(.DATA_W(DATA_W), .TOTAL(TOTAL), .STAGE(MID_STAGE)) u_extract (
        .clk(clk), .rst_n(rst_n), .code(code_in), .raw(raw));

    secded_syndrome #(.TOTAL(TOTAL), .P(P), .STAGE(MID_STAGE)) u_syndrome (
        .clk(clk), .rst_n(rst_n), .code(code_in), .syn(syn));

    secded_correct #(.DATA_W(DATA_W), .TOTAL(TOTAL), .P(P)) u_correct (
        .syn(syn), .mask(mask), .fatal(fatal));

    assign data_c  = raw ^ mask;
    assign clean_c = ~|syn;

    if (OUT_STAGE) begin : g_out_reg
        // Output register for data and the three flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_out   <= '0;
                flag_clean <= 1'b0;
                flag_fixed <= 1'b0;
                flag_fatal <= 1'b0;
            end else begin
                data_out   <= data_c;
                flag_clean <= clean_c;
                flag_fixed <= syn[P];
                flag_fatal <= fatal;
            end
        end
    end else begin : g_out_comb
        assign data_out   = data_c;
        assign flag_clean = clean_c;
        assign flag_fixed = syn[P];
        assign flag_fatal = fatal;
    end

    // Outside reset the three status flags never overlap.
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_clean, flag_fixed, flag_fatal}) <= 1);

    // A fatal result must never come with a clean indication on the same word.
    a_r3_clean_not_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        flag_fatal |-> !flag_clean);
endmodule

// File: tb/tb_secded_decoder.sv
module tb_secded_decoder;
    localparam int DW = 64;
    localparam int PB = 7;
    localparam int TW = DW + PB + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] code_in = '0;
    logic [DW-1:0] d1, d0;
    logic          c1, f1, x1, c0, f0, x0;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    secded_decoder #(.DATA_W(DW), .MID_STAGE(1'b1), .OUT_STAGE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .data_out(d1),
        .flag_clean(c1), .flag_fixed(f1), .flag_fatal(x1));

    secded_decoder #(.DATA_W(DW), .MID_STAGE(1'b0), .OUT_STAGE(1'b0)) dut_comb (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .data_out(d0),
        .flag_clean(c0), .flag_fixed(f0), .flag_fatal(x0));

    // Position of data bit n: n-th non-power-of-two from 1 upward.
    function automatic int pos_of(input int n);
        int cnt = 0;
        int res = 0;
        for (int p = 1; p < TW; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == n) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Build a clean codeword from data.
    function automatic logic [TW-1:0] encode(input logic [DW-1:0] d);
        logic [TW-1:0] w = '0;
        for (int n = 0; n < DW; n++) w[pos_of(n) - 1] = d[n];
        for (int i = 0; i < PB; i++) begin
            logic par = 1'b0;
            for (int p = 1; p < TW; p++)
                if (((p >> i) & 1) == 1 && p != (1 << i)) par ^= w[p - 1];
            w[(1 << i) - 1] = par;
        end
        w[TW-1] = ^w[TW-2:0];
        return w;
    endfunction

    function automatic logic [DW-1:0] extract(input logic [TW-1:0] w);
        logic [DW-1:0] d;
        for (int n = 0; n < DW; n++) d[n] = w[pos_of(n) - 1];
        return d;
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [DW-1:0] got_d, input logic [2:0] got_f,
                       input logic [DW-1:0] exp_d, input logic [2:0] exp_f);
        checks++;
        if (got_d !== exp_d || got_f !== exp_f) begin
            errors++;
            $display("FAIL %s %s: data %h flags %b, expected data %h flags %b",
                     req, what, got_d, got_f, exp_d, exp_f);
        end
    endtask

    // Present one word; check combinational now, registered after two edges (R8).
    task automatic apply(input string req, input logic [TW-1:0] w,
                         input logic [DW-1:0] exp_d, input logic [2:0] exp_f);
        @(negedge clk);
        code_in = w;
        #1;
        cmp(req, "comb", d0, {c0, f0, x0}, exp_d, exp_f);
        @(posedge clk);
        @(posedge clk);
        #1;
        cmp(req, "piped", d1, {c1, f1, x1}, exp_d, exp_f);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] d;
        logic [TW-1:0] w;
        void'($urandom(32'd20240611));
        // R9: registered outputs are zero while reset is held
        code_in = encode(64'hDEAD_BEEF_0123_4567);
        repeat (3) @(posedge clk);
        #1;
        cmp("R9", "reset", d1, {c1, f1, x1}, '0, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R3: clean words, directed and random
        apply("R1", encode('0), '0, 3'b100);
        apply("R1", encode('1), '1, 3'b100);
        apply("R1", encode(64'hA5A5_5A5A_0F0F_F0F0), 64'hA5A5_5A5A_0F0F_F0F0, 3'b100);
        for (int r = 0; r < 8; r++) begin
            d = {$urandom, $urandom};
            apply("R3", encode(d), d, 3'b100);
        end

        // R2: top syndrome bit only (overall parity flip) reads as fixed
        d = 64'h1357_9BDF_2468_ACE0;
        w = encode(d);
        w[TW-1] = ~w[TW-1];
        apply("R2", w, d, 3'b010);

        // R4/R5: every single-bit error on random words
        for (int r = 0; r < 3; r++) begin
            d = {$urandom, $urandom};
            for (int k = 0; k < TW; k++) begin
                w = encode(d);
                w[k] = ~w[k];
                if (k == TW - 1 || ((k + 1) & k) == 0) apply("R5", w, d, 3'b010);
                else                                   apply("R4", w, d, 3'b010);
            end
        end

        // R6: double errors return the raw extraction untouched
        for (int r = 0; r < 200; r++) begin
            int a, b;
            d = {$urandom, $urandom};
            a = $urandom_range(TW - 1, 0);
            b = $urandom_range(TW - 1, 0);
            if (b == a) b = (a + 1) % TW;
            w = encode(d);
            w[a] = ~w[a];
            w[b] = ~w[b];
            apply("R6", w, extract(w), 3'b001);
        end
        // R6: directed double touching overall parity and bit 0
        w = encode('1);
        w[0] = ~w[0];
        w[TW-1] = ~w[TW-1];
        apply("R6", w, extract(w), 3'b001);

        // R8: pipeline shows the old word after one edge, the new after two
        apply("R8", encode(64'h1111), 64'h1111, 3'b100);
        @(negedge clk);
        w = encode(64'h2222);
        w[2] = ~w[2];
        code_in = w;
        @(posedge clk);
        #1;
        cmp("R8", "one edge", d1, {c1, f1, x1}, 64'h1111, 3'b100);
        @(posedge clk);
        #1;
        cmp("R8", "two edges", d1, {c1, f1, x1}, 64'h2222, 3'b010);

        // R9: reset in mid-run clears registered outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        cmp("R9", "mid reset", d1, {c1, f1, x1}, '0, 3'b000);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule